// File: doc/BRIEF.md
# Station Address PROM Access Window

This block holds the 16-byte station address store of a network controller and sits at the bottom of the controller's host-visible register space. A host bus presents an address, an access size of one, two or four bytes, write data and separate read and write strobes. For each access the block decides whether the PROM may be touched in the current I/O mode. A legal access reads or writes the bytes in little-endian order. An illegal read returns all ones across the access width. Accesses above the PROM range that have a legal width are passed to a register-port interface, which the surrounding controller implements.

Two views of the same storage exist, selected by `busView`. In the I/O-port view (`busView` = 0), offsets 0x00 to 0x0F select the PROM and offsets 0x10 to 0x1F go to the register port. The sizes allowed in the PROM range depend on a dword-mode configuration bit. In the memory-mapped view (`busView` = 1), address bit 4 chooses the target. With bit 4 clear, the PROM is reached with any size and no alignment or mode check, and the byte index wraps modulo 16. Writes to the PROM land only while a write-enable configuration bit is set. Both configuration bits are latched from the `cfgLoad` inputs. Read data is registered and comes back one clock after the read strobe.

Top module: `staprom_window`

## Requirements
- R1: After reset the PROM holds the bytes of parameter ROM_INIT (byte i in bits 8i+7:8i), write-enable and dword-mode are 0, and `busRvalid`, `busRdata`, `regRd` and `regWr` are 0.
- R2: A read strobe sampled on a clock edge makes `busRvalid` high for exactly the following cycle, with `busRdata` holding the result; without a read strobe `busRvalid` is low in the next cycle.
- R3: In the I/O view with dword-mode clear, offsets 0x00 to 0x0F accept byte reads at any offset and word reads at even offsets only. Any other PROM-range read returns all ones.
- R4: In the I/O view with dword-mode set, only dword accesses at offsets that are multiples of 4 reach the PROM. Other PROM-range reads return all ones and other PROM-range writes change nothing.
- R5: A legal PROM write changes storage only if write-enable was set when the write was sampled; otherwise it is dropped.
- R6: Multi-byte PROM accesses are little-endian: the byte at the lowest index sits in bits 7:0, and the next bytes sit in 15:8, 23:16 and 31:24.
- R7: In the I/O view, offsets 0x10 to 0x1F with word or dword size drive `regRd` or `regWr` in the same cycle as the strobe, with `regAddr` = address bits 3:0, `regDword` = 1 for dword, and `regWdata` = `busWdata`. Byte accesses there are not forwarded and read all ones. No PROM-range access ever drives the port.
- R8: In the memory view with address bit 4 clear, byte, word and dword accesses reach the PROM at any alignment and in either mode. Byte indices wrap modulo 16.
- R9: In the memory view with address bit 4 set, word and dword accesses go to the register port as in R7. A byte read returns 0x000000FF, and a byte write is ignored.
- R10: An illegal read returns all ones zero-extended to 32 bits (0xFF, 0xFFFF, 0xFFFFFFFF). Size code 3 (reserved) always reads 0xFFFFFFFF and its writes have no effect. Size codes: 0 byte, 1 word, 2 dword.
- R11: A `cfgLoad` pulse latches `cfgWeIn` and `cfgDwIn` as write-enable and dword-mode. Without the pulse, both bits hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busView | input | 1 | 0 = I/O-port view, 1 = memory-mapped view |
| busAddr | input | IDX_W+1 | Access offset |
| busSize | input | 2 | 0 byte, 1 word, 2 dword, 3 reserved |
| busWdata | input | DATA_W | Write data, little-endian lanes |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| cfgLoad | input | 1 | Latch the configuration bits |
| cfgWeIn | input | 1 | New PROM write-enable value |
| cfgDwIn | input | 1 | New dword-mode value |
| busRdata | output | DATA_W | Registered read data |
| busRvalid | output | 1 | Read data valid, one cycle after the read |
| regRd | output | 1 | Register-port read strobe |
| regWr | output | 1 | Register-port write strobe |
| regDword | output | 1 | Register-port access is 32-bit |
| regAddr | output | IDX_W | Register-port offset |
| regWdata | output | DATA_W | Register-port write data |
| regRdata | input | DATA_W | Register-port read data, same cycle as `regRd` |

## Verification
The embedded properties check the following on every cycle: the one-cycle read-valid timing, that PROM contents stay frozen while write-enable is clear, that no PROM-range I/O access reaches the register port, and that the configuration bits hold without a load pulse. They also check the all-ones result for byte reads in the memory view's port half and for byte reads in dword mode. The byte ordering of multi-byte reads and writes, wrap-around of the byte index in the memory view, and the legality table across both modes can only be shown by the bench. The bench replays directed corner cases and seeded random traffic against a byte model of the PROM.

// File: rtl/staprom_pkg.sv
package staprom_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } accSize_e;

  typedef enum logic [1:0] {
    SRC_ROM  = 2'd0,
    SRC_PORT = 2'd1,
    SRC_ONES = 2'd2
  } rdSrc_e;

  typedef struct packed {
    logic       rdEn;
    rdSrc_e     rdSrc;
    logic       romWr;
    logic [3:0] laneMask;
    logic [3:0] baseIdx;
  } dpStrobe_t;

endpackage

// File: rtl/staprom_ctrl.sv
module staprom_ctrl
  import staprom_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busView,
  input  logic [IDX_W:0]   busAddr,
  input  logic [1:0]       busSize,
  input  logic             busWr,
  input  logic             busRd,
  input  logic             cfgLoad,
  input  logic             cfgWeIn,
  input  logic             cfgDwIn,
  output dpStrobe_t        strobe,
  output logic             regRd,
  output logic             regWr,
  output logic             regDword,
  output logic [IDX_W-1:0] regAddr,
  output logic             weBit,
  output logic             dwBit
);

  accSize_e         sizeE;
  logic             hiSel;
  logic [IDX_W-1:0] lowIdx;
  logic             romOk;
  logic             portOk;
  logic             wideOk;

  assign sizeE  = accSize_e'(busSize);
  assign hiSel  = busAddr[IDX_W];
  assign lowIdx = busAddr[IDX_W-1:0];
  assign wideOk = (sizeE == SZ_WORD) || (sizeE == SZ_DWORD);

  always_comb begin
    romOk  = 1'b0;
    portOk = 1'b0;
    if (hiSel) begin
      portOk = wideOk;
    end else if (busView) begin
      romOk = (sizeE != SZ_RSVD);
    end else if (dwBit) begin
      romOk = (sizeE == SZ_DWORD) && (lowIdx[1:0] == 2'b00);
    end else begin
      romOk = (sizeE == SZ_BYTE) || ((sizeE == SZ_WORD) && !lowIdx[0]);
    end
  end

  always_comb begin
    strobe.rdEn    = busRd;
    strobe.rdSrc   = romOk ? SRC_ROM : (portOk ? SRC_PORT : SRC_ONES);
    strobe.romWr   = busWr && romOk && weBit;
    strobe.baseIdx = lowIdx;
    unique case (sizeE)
      SZ_BYTE: strobe.laneMask = 4'b0001;
      SZ_WORD: strobe.laneMask = 4'b0011;
      default: strobe.laneMask = 4'b1111;
    endcase
  end

  assign regRd    = busRd && portOk;
  assign regWr    = busWr && portOk;
  assign regDword = (sizeE == SZ_DWORD);
  assign regAddr  = lowIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weBit <= 1'b0;
      dwBit <= 1'b0;
    end else if (cfgLoad) begin
      weBit <= cfgWeIn;
      dwBit <= cfgDwIn;
    end
  end

  // R7
  io_prom_no_fwd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busView && !hiSel) |-> !(regRd || regWr));

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgLoad |=> $stable({weBit, dwBit}));

endmodule

// File: rtl/staprom_dp.sv
module staprom_dp
  import staprom_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32,
  parameter logic [8*(1<<IDX_W)-1:0] ROM_INIT = '0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobe_t                 strobe,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [DATA_W-1:0]         portRdata,
  output logic [DATA_W-1:0]         rdata,
  output logic                      rvalid,
  output logic [8*(1<<IDX_W)-1:0]   romImage
);

  localparam int ROM_BYTES = 1 << IDX_W;
  localparam int LANES     = DATA_W / 8;
  localparam int LANE_W    = $clog2(LANES);

  logic [7:0]        rom [ROM_BYTES];
  logic [DATA_W-1:0] maskBits;
  logic [DATA_W-1:0] romWord;
  logic [DATA_W-1:0] rdNext;

  for (genvar b = 0; b < ROM_BYTES; b++) begin : g_byte
    logic [IDX_W-1:0] offs;
    logic             hit;
    logic [7:0]       wbyte;

    always_comb begin
      offs  = IDX_W'(b) - strobe.baseIdx;
      hit   = strobe.romWr && (offs < IDX_W'(LANES)) && strobe.laneMask[offs[LANE_W-1:0]];
      wbyte = wdata[8*offs[LANE_W-1:0] +: 8];
    end

    always_ff @(posedge clk) begin
      if (!rstN) rom[b] <= ROM_INIT[8*b +: 8];
      else if (hit) rom[b] <= wbyte;
    end

    assign romImage[8*b +: 8] = rom[b];
  end

  always_comb begin
    logic [IDX_W-1:0] idx;
    for (int k = 0; k < LANES; k++) begin
      idx = strobe.baseIdx + IDX_W'(k);
      maskBits[8*k +: 8] = {8{strobe.laneMask[k]}};
      romWord[8*k +: 8]  = rom[idx];
    end
    unique case (strobe.rdSrc)
      SRC_ROM:  rdNext = romWord & maskBits;
      SRC_PORT: rdNext = portRdata & maskBits;
      default:  rdNext = maskBits;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= strobe.rdEn;
      if (strobe.rdEn) rdata <= rdNext;
    end
  end

  // R2
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdEn |=> rvalid);

  // R2
  rvalid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEn |=> !rvalid);

  // R10
  ones_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && strobe.rdSrc == SRC_ONES) |=> (rdata == $past(maskBits)));

endmodule

// File: rtl/staprom_window.sv
module staprom_window
  import staprom_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32,
  parameter logic [8*(1<<IDX_W)-1:0] ROM_INIT = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busView,
  input  logic [IDX_W:0]    busAddr,
  input  logic [1:0]        busSize,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              cfgLoad,
  input  logic              cfgWeIn,
  input  logic              cfgDwIn,
  output logic [DATA_W-1:0] busRdata,
  output logic              busRvalid,
  output logic              regRd,
  output logic              regWr,
  output logic              regDword,
  output logic [IDX_W-1:0]  regAddr,
  output logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] regRdata
);

  dpStrobe_t                 strobe;
  logic                      weBit;
  logic                      dwBit;
  logic [8*(1<<IDX_W)-1:0]   romImage;

  staprom_ctrl #(.IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busView(busView), .busAddr(busAddr),
    .busSize(busSize), .busWr(busWr), .busRd(busRd), .cfgLoad(cfgLoad),
    .cfgWeIn(cfgWeIn), .cfgDwIn(cfgDwIn), .strobe(strobe), .regRd(regRd),
    .regWr(regWr), .regDword(regDword), .regAddr(regAddr),
    .weBit(weBit), .dwBit(dwBit)
  );

  staprom_dp #(.IDX_W(IDX_W), .DATA_W(DATA_W), .ROM_INIT(ROM_INIT)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(busWdata),
    .portRdata(regRdata), .rdata(busRdata), .rvalid(busRvalid),
    .romImage(romImage)
  );

  assign regWdata = busWdata;

  // R5
  rom_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !weBit |=> $stable(romImage));

  // R9
  mem_hi_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busView && busAddr[IDX_W] && busSize == 2'd0) |=> (busRdata == DATA_W'(8'hFF)));

  // R4
  dw_byte_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !busView && !busAddr[IDX_W] && dwBit && busSize == 2'd0) |=> (busRdata == DATA_W'(8'hFF)));

endmodule

// File: tb/staprom_window_tb.sv
`timescale 1ns/1ps
module staprom_window_tb_top;

  localparam logic [127:0] TB_INIT = 128'h8899AABB_CCDDEEFF_01234567_76543210;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busView = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [1:0]  busSize = '0;
  logic [31:0] busWdata = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic        cfgLoad = 1'b0;
  logic        cfgWeIn = 1'b0;
  logic        cfgDwIn = 1'b0;
  logic [31:0] busRdata;
  logic        busRvalid;
  logic        regRd, regWr, regDword;
  logic [3:0]  regAddr;
  logic [31:0] regWdata;
  logic [31:0] regRdata;

  int testsRun = 0;
  int testsFailed = 0;
  logic [7:0] tbRom [16];
  logic tbWe = 1'b0;
  logic tbDw = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [31:0] portVal(input logic [3:0] a);
    return {4'hC, a, 8'h5A, 4'h3, a, 8'h96};
  endfunction

  assign regRdata = portVal(regAddr);

  staprom_window #(.ROM_INIT(TB_INIT)) dut_i (
    .clk(clk), .rstN(rstN), .busView(busView), .busAddr(busAddr),
    .busSize(busSize), .busWdata(busWdata), .busWr(busWr), .busRd(busRd),
    .cfgLoad(cfgLoad), .cfgWeIn(cfgWeIn), .cfgDwIn(cfgDwIn),
    .busRdata(busRdata), .busRvalid(busRvalid), .regRd(regRd), .regWr(regWr),
    .regDword(regDword), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata)
  );

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] widthOnes(input logic [1:0] sz);
    case (sz)
      2'd0: return 32'h0000_00FF;
      2'd1: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // 0 = PROM, 1 = register port, 2 = all ones / ignored
  function automatic int classify(input logic view, input logic [4:0] a, input logic [1:0] sz);
    logic wide;
    wide = (sz == 2'd1) || (sz == 2'd2);
    if (a[4]) return wide ? 1 : 2;
    if (sz == 2'd3) return 2;
    if (view) return 0;
    if (tbDw) return (sz == 2'd2 && a[1:0] == 2'b00) ? 0 : 2;
    if (sz == 2'd0) return 0;
    if (sz == 2'd1 && !a[0]) return 0;
    return 2;
  endfunction

  function automatic string reqTag(input logic view, input logic [4:0] a, input logic [1:0] sz);
    if (sz == 2'd3) return "R10";
    if (view) return a[4] ? "R9" : "R8";
    if (a[4]) return "R7";
    return tbDw ? "R4" : "R3";
  endfunction

  function automatic logic [31:0] expRead(input int kind, input logic [4:0] a, input logic [1:0] sz);
    logic [31:0] v;
    int n;
    if (kind == 1) return portVal(a[3:0]) & widthOnes(sz);
    if (kind == 2) return widthOnes(sz);
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    v = '0;
    for (int k = 0; k < n; k++) v[8*k +: 8] = tbRom[(a[3:0] + k) & 15];
    return v;
  endfunction

  task automatic doAcc(input logic view, input logic [4:0] a, input logic [1:0] sz,
                       input logic isWr, input logic [31:0] wd, input string tag);
    int kind;
    logic [31:0] expv;
    int n;
    kind = classify(view, a, sz);
    expv = expRead(kind, a, sz);
    @(negedge clk);
    busView = view; busAddr = a; busSize = sz; busWdata = wd;
    busRd = !isWr; busWr = isWr;
    #1;
    chk(regRd == (!isWr && kind == 1), tag, "regRd", {31'd0, regRd}, {31'd0, (!isWr && kind == 1)});
    chk(regWr == (isWr && kind == 1), tag, "regWr", {31'd0, regWr}, {31'd0, (isWr && kind == 1)});
    if (kind == 1) begin
      chk(regAddr == a[3:0], tag, "regAddr", {28'd0, regAddr}, {28'd0, a[3:0]});
      chk(regDword == (sz == 2'd2), tag, "regDword", {31'd0, regDword}, {31'd0, (sz == 2'd2)});
      if (isWr) chk(regWdata == wd, tag, "regWdata", regWdata, wd);
    end
    @(negedge clk);
    if (!isWr) begin
      chk(busRvalid == 1'b1, "R2", "rvalid", {31'd0, busRvalid}, 32'd1);
      chk(busRdata == expv, tag, "rdata", busRdata, expv);
    end else begin
      chk(busRvalid == 1'b0, "R2", "rvalid after write", {31'd0, busRvalid}, 32'd0);
    end
    busRd = 1'b0; busWr = 1'b0;
    if (isWr && kind == 0 && tbWe) begin
      n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      for (int k = 0; k < n; k++) tbRom[(a[3:0] + k) & 15] = wd[8*k +: 8];
    end
  endtask

  task automatic setCfg(input logic we, input logic dw);
    @(negedge clk);
    cfgLoad = 1'b1; cfgWeIn = we; cfgDwIn = dw;
    @(negedge clk);
    cfgLoad = 1'b0;
    tbWe = we; tbDw = dw;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [31:0] r;
    for (int i = 0; i < 16; i++) tbRom[i] = TB_INIT[8*i +: 8];
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busRvalid == 1'b0, "R1", "rvalid", {31'd0, busRvalid}, 32'd0);
    chk(busRdata == 32'd0, "R1", "rdata", busRdata, 32'd0);
    chk(!regRd && !regWr, "R1", "port strobes", {30'd0, regRd, regWr}, 32'd0);
    // R1 contents through the memory view; R8 byte reads anywhere
    for (int i = 0; i < 16; i++) doAcc(1'b1, 5'(i), 2'd0, 1'b0, 32'd0, "R1");
    // R1 dword mode starts clear: I/O byte read at odd offset is legal
    doAcc(1'b0, 5'h03, 2'd0, 1'b0, 32'd0, "R1");
    // R3 word legality and R6 ordering
    doAcc(1'b0, 5'h04, 2'd1, 1'b0, 32'd0, "R6");
    doAcc(1'b0, 5'h05, 2'd1, 1'b0, 32'd0, "R3");
    doAcc(1'b0, 5'h08, 2'd2, 1'b0, 32'd0, "R3");
    // R5 write dropped while write-enable is clear
    doAcc(1'b0, 5'h02, 2'd0, 1'b1, 32'h0000_0011, "R5");
    doAcc(1'b1, 5'h02, 2'd0, 1'b0, 32'd0, "R5");
    // R11 load write-enable, R6 little-endian word write
    setCfg(1'b1, 1'b0);
    doAcc(1'b0, 5'h06, 2'd1, 1'b1, 32'h0000_BEEF, "R6");
    doAcc(1'b1, 5'h06, 2'd0, 1'b0, 32'd0, "R6");
    doAcc(1'b1, 5'h07, 2'd0, 1'b0, 32'd0, "R6");
    // R4 dword mode
    setCfg(1'b1, 1'b1);
    doAcc(1'b0, 5'h08, 2'd2, 1'b0, 32'd0, "R4");
    doAcc(1'b0, 5'h00, 2'd1, 1'b0, 32'd0, "R4");
    doAcc(1'b0, 5'h02, 2'd2, 1'b0, 32'd0, "R4");
    doAcc(1'b0, 5'h01, 2'd0, 1'b0, 32'd0, "R4");
    doAcc(1'b0, 5'h0C, 2'd0, 1'b1, 32'h0000_0077, "R4");
    doAcc(1'b1, 5'h0C, 2'd0, 1'b0, 32'd0, "R4");
    doAcc(1'b0, 5'h0C, 2'd2, 1'b1, 32'hDEAD_F00D, "R6");
    doAcc(1'b1, 5'h0C, 2'd2, 1'b0, 32'd0, "R6");
    // R7 register port from the I/O view
    doAcc(1'b0, 5'h12, 2'd1, 1'b0, 32'd0, "R7");
    doAcc(1'b0, 5'h14, 2'd2, 1'b1, 32'h1357_9BDF, "R7");
    doAcc(1'b0, 5'h13, 2'd0, 1'b1, 32'h0000_00AA, "R7");
    doAcc(1'b0, 5'h1B, 2'd0, 1'b0, 32'd0, "R10");
    // R8 wrap and no mode check in the memory view
    doAcc(1'b1, 5'h0E, 2'd2, 1'b0, 32'd0, "R8");
    doAcc(1'b1, 5'h0F, 2'd1, 1'b1, 32'h0000_C0A7, "R8");
    doAcc(1'b1, 5'h00, 2'd0, 1'b0, 32'd0, "R8");
    // R9 memory view port half
    doAcc(1'b1, 5'h11, 2'd0, 1'b0, 32'd0, "R9");
    doAcc(1'b1, 5'h11, 2'd0, 1'b1, 32'h0000_0055, "R9");
    doAcc(1'b1, 5'h1A, 2'd2, 1'b1, 32'h2468_ACE0, "R9");
    doAcc(1'b1, 5'h16, 2'd1, 1'b0, 32'd0, "R9");
    // R10 reserved size
    doAcc(1'b1, 5'h04, 2'd3, 1'b0, 32'd0, "R10");
    doAcc(1'b1, 5'h04, 2'd3, 1'b1, 32'h9999_9999, "R10");
    doAcc(1'b1, 5'h04, 2'd2, 1'b0, 32'd0, "R10");
    // seeded random traffic
    r = $urandom(32'd4242);
    for (int i = 0; i < 600; i++) begin
      logic v;
      logic [4:0] a;
      logic [1:0] sz;
      logic w;
      if (i % 25 == 0) begin
        r = $urandom;
        setCfg(r[0], r[1]);
      end
      r = $urandom;
      v = r[0]; a = r[5:1]; sz = r[7:6]; w = r[8];
      doAcc(v, a, sz, w, $urandom, reqTag(v, a, sz));
    end
    // final sweep of contents through the legal memory view
    for (int i = 0; i < 16; i++) doAcc(1'b1, 5'(i), 2'd0, 1'b0, 32'd0, "R8");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule